// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received multicast frame should be accepted, based on its 48-bit destination address. It uses a bit-per-bucket hash table of 4096 bits, held as 128 words of 32 bits. The 12-bit bucket index is taken from a window over the two highest address bytes, byte 5 and byte 4. Byte 0 is the first byte on the wire and sits in bits 7:0 of the address input. A 2-bit filter-type setting slides this window so that software can choose which address bits select the bucket.

Software programs the table through a configuration port. It can set one bucket bit at a time by giving its hash value, or it can start a sweep that zeroes every word, one word per cycle. The same sweep runs by itself when reset is released. The lookup port takes an address with a valid strobe. It returns a valid pulse, an accept flag and the computed hash, all at a fixed latency. While a sweep is running, every lookup is answered with reject.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash is ({byte5, byte4, 8'h00} >> (16 - s)) masked to 12 bits, with byte4 = lk_daddr[39:32] and byte5 = lk_daddr[47:40]. For address 56-34-12-00-AA-01, read from byte 5 down to byte 0, the hash is 0x563, 0xAC6, 0x58D and 0x634 for filter types 0 to 3.
- R2: The filter type comes from a 2-bit register, cleared to 0 by reset and loaded from cfg_type_wdata when cfg_type_we is high. Types 0, 1, 2 and 3 give window shifts s of 4, 5, 6 and 8.
- R3: A set command ORs in bit hash[4:0] of table word hash[11:5]. All other bits of that word keep their value.
- R4: res_accept is 1 only when the group bit lk_daddr[0] is 1 and the table bit addressed by the hash is 1.
- R5: A lookup sampled on rising edge k appears on res_valid, res_accept and res_hash after edge k+1. res_valid is high for exactly that one cycle.
- R6: cfg_clr_start, when the block is idle, raises busy after the sampling edge. busy stays high for exactly 128 cycles, and after that every table bit reads as 0.
- R7: A lookup sampled while busy is high still produces res_valid, but with res_accept = 0.
- R8: A set command is ignored while busy is high, and also when cfg_clr_start is high in the same cycle.
- R9: When a set command and a lookup of the same bucket are sampled on the same edge, the lookup sees the table as it was before the set.
- R10: After reset, res_valid and res_accept are 0 and busy is high. An automatic clear then runs, and after it every bucket rejects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_type_we | input | 1 | Write strobe for the filter-type register |
| cfg_type_wdata | input | 2 | New filter type |
| cfg_set_en | input | 1 | Set one table bit |
| cfg_set_hash | input | 12 | Hash value of the bit to set |
| cfg_clr_start | input | 1 | Start a table clear sweep |
| busy | output | 1 | Clear sweep in progress |
| lk_valid | input | 1 | Lookup strobe |
| lk_daddr | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Lookup result valid |
| res_accept | output | 1 | Frame accepted by the hash filter |
| res_hash | output | 12 | Hash computed for the lookup |

## Verification
Lookup results are due after the second rising edge that follows the strobe: one edge into the capture stage and one edge into the result registers. The bench drives each strobe on a falling edge and confirms that res_valid is still low one half cycle after the first edge. It then samples all three result outputs on the falling edge after the second edge. A clear raises busy after the edge that samples the start, and the bench counts the falling edges on which busy is high to confirm the sweep length. Set commands take effect at the next edge, so each set is followed by a lookup only after that edge. The one exception is the same-edge case, which by design must still see the old contents.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  typedef enum logic [1:0] {
    FT_SHIFT4 = 2'd0,
    FT_SHIFT5 = 2'd1,
    FT_SHIFT6 = 2'd2,
    FT_SHIFT8 = 2'd3
  } filt_type_e;

  // extra window shift on top of the base shift, per filter type
  function automatic logic [4:0] extra_shift(input filt_type_e ft);
    case (ft)
      FT_SHIFT5: extra_shift = 5'd1;
      FT_SHIFT6: extra_shift = 5'd2;
      FT_SHIFT8: extra_shift = 5'd4;
      default:   extra_shift = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/mhf_hash.sv
module mhf_hash
  import mhf_pkg::*;
#(
  parameter int HASH_W = 12
) (
  input  logic [47:0]       daddr,
  input  filt_type_e        ftype,
  output logic [HASH_W-1:0] hash,
  output logic              group
);
  localparam logic [4:0] BASE_SHIFT = 5'(HASH_W - 8);

  logic [4:0]  shift_amt;
  logic [23:0] window;

  always_comb begin
    shift_amt = BASE_SHIFT + extra_shift(ftype);
    // {byte5, byte4, zeros} shifted right keeps byte5 << s merged with byte4 >> (8 - s)
    window    = {daddr[47:40], daddr[39:32], 8'h00} >> (5'd16 - shift_amt);
    hash      = window[HASH_W-1:0];
    group     = daddr[0];
  end

endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
  parameter int WORD_BITS = 32,
  parameter int NUM_WORDS = 128,
  localparam int IDX_W = $clog2(NUM_WORDS),
  localparam int BIT_W = $clog2(WORD_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_start,
  input  logic                 set_en,
  input  logic [IDX_W-1:0]     set_word,
  input  logic [BIT_W-1:0]     set_bit,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [WORD_BITS-1:0] rd_word,
  output logic                 busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
  localparam logic [WORD_BITS-1:0] ONE_HOT0 = WORD_BITS'(1);

  logic [WORD_BITS-1:0] mem_q [NUM_WORDS];
  logic                 busy_q, busy_d;
  logic [IDX_W-1:0]     ptr_q, ptr_d;
  logic                 wr_en;
  logic [IDX_W-1:0]     wr_idx;
  logic [WORD_BITS-1:0] wr_data;

  // next-state: sweep has priority, then a new sweep, then single-bit set
  always_comb begin
    busy_d  = busy_q;
    ptr_d   = ptr_q;
    wr_en   = 1'b0;
    wr_idx  = set_word;
    wr_data = mem_q[set_word] | (ONE_HOT0 << set_bit);
    if (busy_q) begin
      wr_en   = 1'b1;
      wr_idx  = ptr_q;
      wr_data = '0;
      ptr_d   = ptr_q + 1'b1;
      if (ptr_q == LAST_IDX) busy_d = 1'b0;
    end else if (clr_start) begin
      busy_d = 1'b1;
      ptr_d  = '0;
    end else if (set_en) begin
      wr_en = 1'b1;
    end
  end

  // control registers; reset starts a sweep
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      ptr_q  <= ptr_d;
    end
  end

  // storage without reset, written through one enabled port
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_word = mem_q[rd_idx];
  assign busy    = busy_q;

  assert_sweep_starts_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (ptr_q == '0) && $past(clr_start));

  assert_sweep_covers_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(ptr_q) == LAST_IDX);

endmodule

// File: rtl/mhf_lookup.sv
module mhf_lookup #(
  parameter int HASH_W    = 12,
  parameter int WORD_BITS = 32,
  localparam int BIT_W = $clog2(WORD_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  input  logic [HASH_W-1:0]    hash,
  input  logic                 group,
  input  logic                 busy,
  input  logic [WORD_BITS-1:0] rd_word,
  output logic                 res_valid,
  output logic                 res_accept,
  output logic [HASH_W-1:0]    res_hash
);
  logic                 s1_valid_q;
  logic                 s1_ok_q, s1_ok_d;
  logic [HASH_W-1:0]    s1_hash_q;
  logic [WORD_BITS-1:0] s1_word_q;
  logic                 res_valid_q;
  logic                 res_accept_q, res_accept_d;
  logic [HASH_W-1:0]    res_hash_q;

  always_comb begin
    s1_ok_d      = group & ~busy;
    res_accept_d = s1_valid_q & s1_ok_q & s1_word_q[s1_hash_q[BIT_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q   <= 1'b0;
      s1_ok_q      <= 1'b0;
      res_valid_q  <= 1'b0;
      res_accept_q <= 1'b0;
    end else begin
      s1_valid_q  <= lk_valid;
      res_valid_q <= s1_valid_q;
      if (lk_valid)   s1_ok_q      <= s1_ok_d;
      if (s1_valid_q) res_accept_q <= res_accept_d;
      else            res_accept_q <= 1'b0;
    end
  end

  // data path registers, enabled, no reset
  always_ff @(posedge clk) begin
    if (lk_valid) begin
      s1_hash_q <= hash;
      s1_word_q <= rd_word;
    end
    if (s1_valid_q) res_hash_q <= s1_hash_q;
  end

  assign res_valid  = res_valid_q;
  assign res_accept = res_accept_q;
  assign res_hash   = res_hash_q;

  assert_accept_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> res_valid);

  assert_fixed_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(lk_valid, 2));

  assert_group_required_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> $past(group, 2));

  assert_busy_rejects_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_valid, 2) && $past(busy, 2)) |-> !res_accept);

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int HASH_W    = 12,
  parameter int WORD_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_type_we,
  input  logic [1:0]        cfg_type_wdata,
  input  logic              cfg_set_en,
  input  logic [HASH_W-1:0] cfg_set_hash,
  input  logic              cfg_clr_start,
  output logic              busy,
  input  logic              lk_valid,
  input  logic [47:0]       lk_daddr,
  output logic              res_valid,
  output logic              res_accept,
  output logic [HASH_W-1:0] res_hash
);
  localparam int BIT_W     = $clog2(WORD_BITS);
  localparam int IDX_W     = HASH_W - BIT_W;
  localparam int NUM_WORDS = 2 ** IDX_W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // filter-type register
  filt_type_e ftype_q, ftype_d;

  always_comb begin
    ftype_d = ftype_q;
    if (cfg_type_we) ftype_d = filt_type_e'(cfg_type_wdata);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ftype_q <= FT_SHIFT4;
    else            ftype_q <= ftype_d;
  end

  logic [HASH_W-1:0]    lk_hash;
  logic                 lk_group;
  logic [WORD_BITS-1:0] rd_word;
  logic                 busy_w;

  mhf_hash #(.HASH_W(HASH_W)) u_hash (
    .daddr (lk_daddr),
    .ftype (ftype_q),
    .hash  (lk_hash),
    .group (lk_group)
  );

  mhf_table #(.WORD_BITS(WORD_BITS), .NUM_WORDS(NUM_WORDS)) u_table (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_start (cfg_clr_start),
    .set_en    (cfg_set_en),
    .set_word  (cfg_set_hash[HASH_W-1:BIT_W]),
    .set_bit   (cfg_set_hash[BIT_W-1:0]),
    .rd_idx    (lk_hash[HASH_W-1:BIT_W]),
    .rd_word   (rd_word),
    .busy      (busy_w)
  );

  mhf_lookup #(.HASH_W(HASH_W), .WORD_BITS(WORD_BITS)) u_lookup (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lk_valid   (lk_valid),
    .hash       (lk_hash),
    .group      (lk_group),
    .busy       (busy_w),
    .rd_word    (rd_word),
    .res_valid  (res_valid),
    .res_accept (res_accept),
    .res_hash   (res_hash)
  );

  assign busy = busy_w;

  assert_type_reset_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!$past(cfg_type_we) && $past(rst_int_n)) |-> $stable(ftype_q));

endmodule

// File: tb/mcast_hash_filter_tb_top.sv
`timescale 1ns/1ps
module mcast_hash_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_type_we;
  logic [1:0]  cfg_type_wdata;
  logic        cfg_set_en;
  logic [11:0] cfg_set_hash;
  logic        cfg_clr_start;
  logic        busy;
  logic        lk_valid;
  logic [47:0] lk_daddr;
  logic        res_valid;
  logic        res_accept;
  logic [11:0] res_hash;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mcast_hash_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_type_we(cfg_type_we), .cfg_type_wdata(cfg_type_wdata),
    .cfg_set_en(cfg_set_en), .cfg_set_hash(cfg_set_hash),
    .cfg_clr_start(cfg_clr_start), .busy(busy),
    .lk_valid(lk_valid), .lk_daddr(lk_daddr),
    .res_valid(res_valid), .res_accept(res_accept), .res_hash(res_hash)
  );

  // {filter type, address, expected hash}
  localparam logic [61:0] VEC [8] = '{
    {2'd0, 48'h5634_1200_AA01, 12'h563},
    {2'd1, 48'h5634_1200_AA01, 12'hAC6},
    {2'd2, 48'h5634_1200_AA01, 12'h58D},
    {2'd3, 48'h5634_1200_AA01, 12'h634},
    {2'd0, 48'hA5C3_0000_0001, 12'hA5C},
    {2'd1, 48'hA5C3_0000_0001, 12'h4B8},
    {2'd2, 48'hA5C3_0000_0001, 12'h970},
    {2'd3, 48'hA5C3_0000_0001, 12'h5C3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_type(input logic [1:0] t);
    @(negedge clk);
    cfg_type_we = 1'b1; cfg_type_wdata = t;
    @(negedge clk);
    cfg_type_we = 1'b0;
  endtask

  task automatic set_bit(input logic [11:0] h);
    @(negedge clk);
    cfg_set_en = 1'b1; cfg_set_hash = h;
    @(negedge clk);
    cfg_set_en = 1'b0;
  endtask

  // starts at a falling edge, ends at the falling edge where results are sampled
  task automatic lookup(input logic [47:0] a, output logic acc, output logic [11:0] h,
                        output logic vld, output logic early);
    @(negedge clk);
    lk_valid = 1'b1; lk_daddr = a;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    early = res_valid;
    @(posedge clk);
    @(negedge clk);
    acc = res_accept; h = res_hash; vld = res_valid;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic acc, vld, early;
    logic [11:0] h;
    int n;
    rst_n = 1'b0; cfg_type_we = 0; cfg_type_wdata = 0; cfg_set_en = 0;
    cfg_set_hash = 0; cfg_clr_start = 0; lk_valid = 0; lk_daddr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset res_valid", res_valid, 0);
    chk("R10 reset res_accept", res_accept, 0);
    chk("R10 reset busy", busy, 1);
    rst_n = 1'b1;
    @(negedge clk);
    wait_idle(n);
    chk("R10 auto clear ends", (n >= 128 && n <= 140), 1);

    // vector table: hash per filter type, empty table rejects
    for (int i = 0; i < 8; i++) begin
      set_type(VEC[i][61:60]);
      lookup(VEC[i][59:12], acc, h, vld, early);
      chk("R1 hash", h, VEC[i][11:0]);
      chk("R2 type select hash", h, VEC[i][11:0]);
      chk("R10 empty table rejects", acc, 0);
      chk("R5 valid after two edges", vld, 1);
      chk("R5 not valid after one edge", early, 0);
    end
    @(negedge clk);
    chk("R5 valid one cycle", res_valid, 0);

    // set and lookup, type 0
    set_type(2'd0);
    set_bit(12'h563);
    lookup(48'h5634_1200_AA01, acc, h, vld, early);
    chk("R4 set bucket accepts", acc, 1);
    lookup(48'h5634_1200_AA00, acc, h, vld, early);
    chk("R4 group bit clear rejects", acc, 0);
    set_bit(12'h562);
    lookup(48'h5634_1200_AA01, acc, h, vld, early);
    chk("R3 OR keeps earlier bit", acc, 1);
    lookup(48'h5620_0000_0001, acc, h, vld, early);
    chk("R3 new bit set", acc, 1);
    lookup(48'h5640_0000_0001, acc, h, vld, early);
    chk("R3 neighbour bit untouched", acc, 0);
    lookup(48'h5830_0000_0001, acc, h, vld, early);
    chk("R3 other word untouched", acc, 0);

    // type change moves the window
    set_type(2'd3);
    lookup(48'h5634_1200_AA01, acc, h, vld, early);
    chk("R2 type 3 hash", h, 12'h634);
    chk("R2 type 3 bucket empty", acc, 0);

    // same-edge set and lookup of one bucket: old contents
    @(negedge clk);
    cfg_set_en = 1'b1; cfg_set_hash = 12'h6A0;
    lk_valid = 1'b1; lk_daddr = 48'h06A0_0000_0001;
    @(posedge clk);
    @(negedge clk);
    cfg_set_en = 1'b0; lk_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 same edge sees old", res_accept, 0);
    chk("R9 result valid", res_valid, 1);
    lookup(48'h06A0_0000_0001, acc, h, vld, early);
    chk("R9 later lookup sees set", acc, 1);

    // clear sweep
    @(negedge clk);
    cfg_clr_start = 1'b1;
    @(negedge clk);
    cfg_clr_start = 1'b0;
    chk("R6 busy after start", busy, 1);
    lookup(48'h06A0_0000_0001, acc, h, vld, early);
    chk("R7 busy lookup valid", vld, 1);
    chk("R7 busy lookup rejects", acc, 0);
    set_bit(12'h777);
    n = 5;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk("R6 busy length", n, 128);
    lookup(48'h06A0_0000_0001, acc, h, vld, early);
    chk("R6 table cleared", acc, 0);
    lookup(48'h0777_0000_0001, acc, h, vld, early);
    chk("R8 set during busy ignored", acc, 0);

    // set together with clear start is dropped
    @(negedge clk);
    cfg_clr_start = 1'b1; cfg_set_en = 1'b1; cfg_set_hash = 12'h111;
    @(negedge clk);
    cfg_clr_start = 1'b0; cfg_set_en = 1'b0;
    wait_idle(n);
    lookup(48'h0111_0000_0001, acc, h, vld, early);
    chk("R8 set with clear start ignored", acc, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule